// File: doc/BRIEF.md
# Symmetric Bit-Layer FIR Filter Engine

This block applies a programmable 127-tap linear-phase (type I) FIR filter to 8-bit signed samples without any multiplier. The coefficients are never stored as numbers. A host writes them into a code store as compressed ternary bit layers: each code names a nonzero digit of +1 or -1 and the count of zero digits skipped to reach it, and a separate end-of-layer code closes each layer. Because the coefficients are symmetric, only the 64 coefficients from the outer tap up to the centre tap are coded. For each coded digit the engine reads the two samples that mirror each other about the centre, pre-adds them and then adds or subtracts the sum in a right-shifting accumulator.

Samples arrive on a valid/ready stream into a 127-entry circular memory that always holds the most recent 127 samples. The stream is back-pressured while a run is in progress: `smp_ready` is low from the accepted start until `done`, so a sample offered during a run waits and is accepted on the first edge after the run ends. A run starts on a `start` pulse. The run takes exactly one cycle per code, including the end-of-layer codes. At each end-of-layer code the accumulator shifts right and its lowest bit is captured as one settled bit of the result. After the sixteenth layer the accumulator joined with the 16 captured bits forms the exact, unrounded filter output. This output stays on `res_data` until the next run is accepted.

Top module: `blf_symfir`

## Requirements
- R1: After reset `busy` and `done` are 0, `smp_ready` is 1, `res_data` is 0, and all 127 stored samples read as 0.
- R2: A sample is stored on each edge where `smp_valid` and `smp_ready` are both 1. It replaces the oldest sample. Tap j (j = 0..126) means the j-th oldest stored sample, so tap 126 is the newest.
- R3: Each code is 8 bits. Bit 7 is the digit sign (0 adds, 1 subtracts) and bits 6:0 are the zero-run count. The value 8'hFF is the end-of-layer code. Codes are fetched from address 0 upward. The first layer is coefficient bit 0 and the run ends after the 16th end-of-layer code.
- R4: A digit code selects coefficient index k = (index after the previous digit in this layer, starting at 0) + run. For k < 63 the operand is tap k + tap 126-k. For k = 63 the operand is tap 63 alone. For k > 63 the code adds nothing.
- R5: When `done` is 1, `res_data` is the exact 33-bit two's-complement value of sum over k<63 of w_k*(x_k+x_(126-k)), plus w_63*x_63.
- R6: With N codes in the program, `done` goes to 1 for exactly one cycle, N clock edges after the edge that accepted `start`. `busy` is 1 in between, and `res_data` holds its value after `done` until the next accepted start.
- R7: `start` is ignored while `busy` is 1 or while `smp_valid` is 1.
- R8: `smp_ready` is 0 while `busy` is 1. A sample offered during a run changes neither that run's result nor the stored samples until the run ends.
- R9: Code writes (`cw_en`) take effect only while `busy` is 0. A write offered during a run is dropped.
- R10: Several digits in one layer are accumulated in code order, and the index restarts at 0 at every layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_en | input | 1 | Code write strobe |
| cw_addr | input | 8 | Code store address |
| cw_data | input | 8 | Code value (sign, zero run, or 8'hFF end of layer) |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready, low during a run |
| smp_data | input | 8 | Signed sample |
| start | input | 1 | Run request pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the result is complete |
| res_data | output | 33 | Full-precision signed filter output |

## Verification
The bench builds the block with its default parameters: 127 taps, 16 coefficient layers and a 256-entry code store. This lets it sweep every one of the 64 coefficient positions on its own, so each mirrored tap pair and the lone centre tap are checked for every index. At the same size it also reaches both coefficient extremes against full-scale samples of both signs, which are the largest results the 33-bit output has to carry. Dense random coefficient sets are scaled down until their codes fit in 256 entries. This exercises multi-digit layers near the code budget, and the cycle count of every run is compared with the code count.

// File: rtl/blf_pkg.sv
package blf_pkg;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned RUN_W   = CODE_W - 1;
  localparam logic [CODE_W-1:0] LAYER_END = 8'hFF;

  typedef struct packed {
    logic             neg;
    logic [RUN_W-1:0] run;
  } code_t;
endpackage

// File: rtl/blf_sample_ring.sv
module blf_sample_ring #(
  parameter int DEPTH = 127,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [PW-1:0] tap_a,
  input  logic [PW-1:0] tap_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [PW-1:0] wptr_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr;

  function automatic logic [PW-1:0] phys(input logic [PW-1:0] base, input logic [PW-1:0] tap);
    logic [PW:0] s;
    s = {1'b0, base} + {1'b0, tap};
    if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wptr] <= wr_data;
      wptr      <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
    end
  end

  assign rd_a   = mem[phys(wptr, tap_a)];
  assign rd_b   = mem[phys(wptr, tap_b)];
  assign wptr_o = wptr;

  AST_WPTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wptr < PW'(DEPTH)); // R2
  AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !$stable(wptr)); // R2
endmodule

// File: rtl/blf_code_store.sv
module blf_code_store #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/blf_layer_acc.sv
module blf_layer_acc #(
  parameter int OP_W = 9,
  parameter int AW   = 17,
  parameter int FW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 add_en,
  input  logic                 sub,
  input  logic signed [OP_W-1:0] op,
  input  logic                 shift_en,
  output logic [AW-1:0]        acc_o,
  output logic [FW-1:0]        frac_o
);
  logic signed [AW-1:0] acc;
  logic [FW-1:0]        frac;
  logic signed [AW:0]   acc_ext, op_ext, sum_w;

  always_comb begin
    acc_ext = {acc[AW-1], acc};
    op_ext  = {{(AW+1-OP_W){op[OP_W-1]}}, op};
    sum_w   = sub ? (acc_ext - op_ext) : (acc_ext + op_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      frac <= '0;
    end else if (clr) begin
      acc  <= '0;
      frac <= '0;
    end else if (shift_en) begin
      frac <= {acc[0], frac[FW-1:1]};
      acc  <= {acc[AW-1], acc[AW-1:1]};
    end else if (add_en) begin
      acc  <= sum_w[AW-1:0];
    end
  end

  assign acc_o  = acc;
  assign frac_o = frac;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |-> (sum_w[AW] == sum_w[AW-1])); // R5
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_en && shift_en)); // R3
endmodule

// File: rtl/blf_symfir.sv
module blf_symfir #(
  parameter int NTAP       = 127,
  parameter int SMP_W      = 8,
  parameter int COEF_W     = 16,
  parameter int CODE_DEPTH = 256,
  localparam int CA_W      = $clog2(CODE_DEPTH),
  localparam int NHALF     = (NTAP + 1) / 2,
  localparam int OP_W      = SMP_W + 1,
  localparam int AW        = OP_W + $clog2(NHALF) + 2,
  localparam int RES_W     = AW + COEF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cw_en,
  input  logic [CA_W-1:0]       cw_addr,
  input  logic [blf_pkg::CODE_W-1:0] cw_data,
  input  logic                  smp_valid,
  output logic                  smp_ready,
  input  logic [SMP_W-1:0]      smp_data,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic [RES_W-1:0]      res_data
);
  import blf_pkg::*;

  localparam int TAP_W = $clog2(NTAP);
  localparam int IX_W  = TAP_W + 1;
  localparam int LAY_W = $clog2(COEF_W);

  logic [CA_W-1:0]   pc;
  logic [IX_W-1:0]   cur;
  logic [LAY_W-1:0]  layer;
  logic [CODE_W-1:0] code_raw;
  code_t             code;
  logic              is_end, last_layer, go;
  logic [IX_W-1:0]   idx;
  logic              in_range, centre;
  logic [TAP_W-1:0]  tap_a, tap_b, wptr;
  logic [SMP_W-1:0]  smp_a, smp_b;
  logic signed [OP_W-1:0] operand;
  logic [AW-1:0]     acc;
  logic [COEF_W-1:0] frac;

  assign smp_ready = !busy;
  assign go        = start && !busy && !smp_valid;

  blf_code_store #(.DEPTH(CODE_DEPTH), .W(CODE_W)) u_codes (
    .clk(clk), .wr_en(cw_en && !busy), .wr_addr(cw_addr), .wr_data(cw_data),
    .rd_addr(pc), .rd_data(code_raw));

  blf_sample_ring #(.DEPTH(NTAP), .W(SMP_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(smp_valid && smp_ready), .wr_data(smp_data),
    .tap_a(tap_a), .tap_b(tap_b), .rd_a(smp_a), .rd_b(smp_b), .wptr_o(wptr));

  // Decode: index of this digit and the mirrored tap pair it selects.
  always_comb begin
    code       = code_t'(code_raw);
    is_end     = (code_raw == LAYER_END);
    last_layer = (layer == LAY_W'(COEF_W-1));
    idx        = cur + IX_W'(code.run);
    in_range   = idx < IX_W'(NHALF);
    centre     = idx == IX_W'(NHALF-1);
    tap_a      = in_range ? idx[TAP_W-1:0] : '0;
    tap_b      = TAP_W'(NTAP-1) - tap_a;
    if (centre)
      operand = OP_W'($signed(smp_a));
    else if (in_range)
      operand = OP_W'($signed(smp_a)) + OP_W'($signed(smp_b));
    else
      operand = '0;
  end

  blf_layer_acc #(.OP_W(OP_W), .AW(AW), .FW(COEF_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .add_en(busy && !is_end), .sub(code.neg), .op(operand),
    .shift_en(busy && is_end), .acc_o(acc), .frac_o(frac));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pc    <= '0;
      cur   <= '0;
      layer <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        pc    <= '0;
        cur   <= '0;
        layer <= '0;
      end else if (busy) begin
        pc <= pc + 1'b1;
        if (is_end) begin
          cur   <= '0;
          layer <= layer + 1'b1;
          if (last_layer) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          cur <= in_range ? idx + 1'b1 : IX_W'(NHALF);
        end
      end
    end
  end

  assign res_data = {acc, frac};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && smp_valid && !busy) |=> !busy); // R7
  AST_RING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wptr)); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(res_data)); // R6
endmodule

// File: tb/blf_symfir_test.sv
`timescale 1ns/1ps
module blf_symfir_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_en = 1'b0;
  logic [7:0]  cw_addr = '0;
  logic [7:0]  cw_data = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [7:0]  smp_data = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [32:0] res_data;

  blf_symfir uut (
    .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .start(start), .busy(busy), .done(done), .res_data(res_data));

  always #2.5 clk = ~clk;

  int          errs = 0;
  int          checks = 0;
  int          hist [127];
  int          wts [64];
  logic [7:0]  codes [256];
  int          ncodes;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic longint expect_y();
    longint s = 0;
    for (int j = 0; j < 63; j++) s += longint'(wts[j]) * longint'(hist[j] + hist[126-j]);
    s += longint'(wts[63]) * longint'(hist[63]);
    return s;
  endfunction

  // Signed-digit (nonzero digits never adjacent) encoding into run-length codes.
  function automatic int encode();
    int dig [64][16];
    int n = 0;
    for (int j = 0; j < 64; j++) begin
      int w = wts[j];
      for (int i = 0; i < 16; i++) begin
        int d = 0;
        if (w % 2 != 0) d = ((((w % 4) + 4) % 4) == 1) ? 1 : -1;
        dig[j][i] = d;
        w = (w - d) / 2;
      end
    end
    for (int i = 0; i < 16; i++) begin
      int cur = 0;
      for (int j = 0; j < 64; j++) begin
        if (dig[j][i] != 0) begin
          if (n < 256) codes[n] = {(dig[j][i] < 0), 7'(j - cur)};
          n++;
          cur = j + 1;
        end
      end
      if (n < 256) codes[n] = 8'hFF;
      n++;
    end
    return (n > 256) ? -1 : n;
  endfunction

  task automatic load_codes();
    for (int a = 0; a < ncodes; a++) begin
      @(negedge clk);
      cw_en = 1'b1; cw_addr = 8'(a); cw_data = codes[a];
    end
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic set_filter();
    int n = encode();
    while (n < 0) begin
      for (int j = 0; j < 64; j++) wts[j] = wts[j] / 2;
      n = encode();
    end
    ncodes = n;
    load_codes();
  endtask

  task automatic push(input int v);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 8'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    for (int k = 0; k < 126; k++) hist[k] = hist[k+1];
    hist[126] = v;
  endtask

  // One run; optionally offers a sample and a code write while busy.
  task automatic do_run(input string req, input longint exp, input bit pend, input int pv,
                        input bit poke);
    int cyc = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (pend) begin
      smp_valid = 1'b1; smp_data = 8'(pv);
      check(smp_ready == 1'b0, "R8", "ready during run", longint'(smp_ready), 0);
    end
    if (poke) begin
      cw_en = 1'b1; cw_addr = 8'd0; cw_data = 8'h00;
    end
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cw_en = 1'b0;
      cyc++;
    end
    check(longint'($signed(res_data)) == exp, req, "result", longint'($signed(res_data)), exp);
    check(cyc == ncodes, "R6", "run cycles", cyc, ncodes);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6", "done width", longint'(done), 0);
    check(longint'($signed(res_data)) == exp, "R6", "held result", longint'($signed(res_data)), exp);
    if (pend) begin
      smp_valid = 1'b0;
      for (int k = 0; k < 126; k++) hist[k] = hist[k+1];
      hist[126] = pv;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 127; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done", longint'({busy, done}), 0);
    check(smp_ready == 1'b1, "R1", "ready", longint'(smp_ready), 1);
    check(res_data == '0, "R1", "result", longint'(res_data), 0);

    // R1 cleared samples seen through a run
    for (int j = 0; j < 64; j++) wts[j] = 0;
    wts[0] = 3; wts[63] = -7; wts[20] = 1000;
    set_filter();
    do_run("R1", 0, 1'b0, 0, 1'b0);

    // R2 R5 full window of random samples
    for (int k = 0; k < 127; k++) push(int'(nxt() % 256) - 128);
    do_run("R5", expect_y(), 1'b0, 0, 1'b0);

    // R4 sweep every coefficient position alone
    for (int p = 0; p < 64; p++) begin
      for (int j = 0; j < 64; j++) wts[j] = 0;
      wts[p] = ((p * 1031) % 65536) - 32768;
      set_filter();
      do_run("R4", expect_y(), 1'b0, 0, 1'b0);
    end

    // R5 extremes
    for (int j = 0; j < 64; j++) wts[j] = -32768;
    set_filter();
    for (int k = 0; k < 127; k++) push(-128);
    do_run("R5", expect_y(), 1'b0, 0, 1'b0);
    for (int j = 0; j < 64; j++) wts[j] = 32767;
    set_filter();
    do_run("R5", expect_y(), 1'b0, 0, 1'b0);
    for (int k = 0; k < 127; k++) push(127);
    do_run("R5", expect_y(), 1'b0, 0, 1'b0);

    // R10 R2 dense random filters over a streaming window
    for (int sh = 0; sh < 6; sh++) begin
      for (int j = 0; j < 64; j++) wts[j] = (int'(nxt() % 65536) - 32768) >>> sh;
      set_filter();
      for (int s = 0; s < 4; s++) begin
        push(int'(nxt() % 256) - 128);
        do_run("R10", expect_y(), 1'b0, 0, 1'b0);
      end
    end

    // R4 index beyond the centre adds nothing: +k5, then run 70 -> k=76
    codes[0] = 8'h05; codes[1] = 8'h46;
    for (int a = 2; a < 18; a++) codes[a] = 8'hFF;
    ncodes = 18;
    load_codes();
    do_run("R4", longint'(hist[5] + hist[121]), 1'b0, 0, 1'b0);

    // R7 start with a pending sample is refused; the sample is taken
    for (int j = 0; j < 64; j++) wts[j] = (int'(nxt() % 4096) - 2048);
    set_filter();
    @(negedge clk);
    start = 1'b1; smp_valid = 1'b1; smp_data = 8'(-77);
    @(negedge clk);
    start = 1'b0; smp_valid = 1'b0;
    for (int k = 0; k < 126; k++) hist[k] = hist[k+1];
    hist[126] = -77;
    check(busy == 1'b0, "R7", "busy after refused start", longint'(busy), 0);
    do_run("R7", expect_y(), 1'b0, 0, 1'b0);

    // R8 sample held during a run; R9 code write during run dropped
    do_run("R8", expect_y(), 1'b1, 55, 1'b1);
    do_run("R9", expect_y(), 1'b0, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule